// File: doc/BRIEF.md
# Column Skew Dispatcher for a Systolic Array

This block sits in front of a systolic array and turns one row of activation values, presented together for every column, into a diagonal wavefront. Column k receives its own activation, its own copy of a 3-bit opcode and the two matching valid flags exactly k+1 clock cycles after they were presented. Each column therefore enters the array one cycle behind its left neighbour.

The activation path and the opcode path are skewed independently. Each carries its own valid flag. A data register loads only when valid data arrives at it, so a bubble travels down the skew with its valid low and never re-reports old data as new. Each activation is also adapted to the array's input width. A wider output is zero-extended. A narrower output keeps the low bits.

Top module: `skew_dispatch`

## Requirements
- R1: While reset is asserted every output (column data, data valid, opcode, opcode valid) is zero.
- R2: `col_act_vld[k]` equals `act_vld` as it was sampled k+1 rising edges earlier, for every column k.
- R3: `col_op_vld[k]` equals `op_vld` sampled k+1 edges earlier, independently of `act_vld`.
- R4: When `col_act_vld[k]` is high, `col_act[k*OUT_W +: OUT_W]` holds the slice `act_in[k*IN_W +: IN_W]` sampled k+1 edges earlier, zero-extended when OUT_W > IN_W.
- R5: A cycle with `act_vld` low does not overwrite column data. Each column keeps showing the last valid value that reached it, or zero if none has.
- R6: When `col_op_vld[k]` is high, `col_op[k*3 +: 3]` holds `op_in` sampled k+1 edges earlier.
- R7: A cycle with `op_vld` low does not overwrite a column's opcode. Each column keeps its last valid opcode, or zero if none has arrived.
- R8: When OUT_W < IN_W, each column's data is the low OUT_W bits of its input slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| act_in | input | NUM_COLS*IN_W | One activation per column, column k at bits [k*IN_W +: IN_W] |
| act_vld | input | 1 | Activation row valid |
| op_in | input | 3 | Opcode broadcast to all columns |
| op_vld | input | 1 | Opcode valid |
| col_act | output | NUM_COLS*OUT_W | Skewed, width-adapted activation, column k at [k*OUT_W +: OUT_W] |
| col_act_vld | output | NUM_COLS | Per-column data valid |
| col_op | output | NUM_COLS*3 | Skewed opcode, column k at [k*3 +: 3] |
| col_op_vld | output | NUM_COLS | Per-column opcode valid |

## Verification
The hardest case to reach is a column showing data that was loaded long ago while its valid flag is low. This is the state where a wrongly loaded or wrongly flagged register would leak stale values. Combined with it is the case where the data and opcode valids disagree in the same column. The stimulus reaches both with isolated single-cycle pulses separated by long idle stretches, with complementary data and opcode valid patterns, and with random valid densities. Fresh random data is driven even in invalid cycles, so any illegal load shows up as a mismatch.

// File: rtl/skew_pkg.sv
package skew_pkg;
  localparam int OP_W = 3;
  typedef logic [OP_W-1:0] op_t;
endpackage

// File: rtl/skew_fit.sv
module skew_fit #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 12
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W > IN_W) begin : g_widen
      assign dout = {{(OUT_W-IN_W){1'b0}}, din};
    end else if (OUT_W == IN_W) begin : g_same
      assign dout = din;
    end else begin : g_narrow
      logic [IN_W-OUT_W-1:0] dropped;
      assign dout    = din[OUT_W-1:0];
      assign dropped = din[IN_W-1:OUT_W];
    end
  endgenerate
endmodule

// File: rtl/skew_line.sv
module skew_line #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         din_vld,
  output logic [W-1:0] dout,
  output logic         dout_vld
);
  logic [DEPTH:0][W-1:0] feed_d;
  logic [DEPTH:0]        feed_v;

  assign feed_d[0] = din;
  assign feed_v[0] = din_vld;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] d_q, d_nxt;
    logic         v_q, v_nxt, ld;

    always_comb begin
      ld    = feed_v[i];
      d_nxt = feed_d[i];
      v_nxt = feed_v[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        v_q <= 1'b0;
      end else begin
        v_q <= v_nxt;
        if (ld) d_q <= d_nxt;
      end
    end

    assign feed_d[i+1] = d_q;
    assign feed_v[i+1] = v_q;
  end

  assign dout     = feed_d[DEPTH];
  assign dout_vld = feed_v[DEPTH];
endmodule

// File: rtl/skew_dispatch.sv
module skew_dispatch
  import skew_pkg::*;
#(
  parameter int NUM_COLS = 32,
  parameter int IN_W     = 8,
  parameter int OUT_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_COLS*IN_W-1:0]  act_in,
  input  logic                      act_vld,
  input  logic [2:0]                op_in,
  input  logic                      op_vld,
  output logic [NUM_COLS*OUT_W-1:0] col_act,
  output logic [NUM_COLS-1:0]       col_act_vld,
  output logic [NUM_COLS*3-1:0]     col_op,
  output logic [NUM_COLS-1:0]       col_op_vld
);
  localparam int AW = OUT_W;

  // Data: each column owns a line of depth c+1 (triangular storage).
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [AW-1:0] fitted;

    skew_fit #(.IN_W(IN_W), .OUT_W(OUT_W)) i_fit (
      .din  (act_in[c*IN_W +: IN_W]),
      .dout (fitted)
    );

    skew_line #(.W(AW), .DEPTH(c+1)) i_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (fitted),
      .din_vld  (act_vld),
      .dout     (col_act[c*AW +: AW]),
      .dout_vld (col_act_vld[c])
    );

    // Opcode: one shared chain, each column taps one stage further on.
    op_t op_src;
    logic op_src_vld;
    if (c == 0) begin : g_head
      assign op_src     = op_in;
      assign op_src_vld = op_vld;
    end else begin : g_link
      assign op_src     = col_op[(c-1)*OP_W +: OP_W];
      assign op_src_vld = col_op_vld[c-1];
    end

    skew_line #(.W(OP_W), .DEPTH(1)) i_op (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (op_src),
      .din_vld  (op_src_vld),
      .dout     (col_op[c*OP_W +: OP_W]),
      .dout_vld (col_op_vld[c])
    );
  end
endmodule

// File: rtl/skew_dispatch_chk.sv
module skew_dispatch_chk #(
  parameter int NUM_COLS = 32,
  parameter int IN_W     = 8,
  parameter int OUT_W    = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [IN_W-1:0]           act_in0,
  input logic                      act_vld,
  input logic [2:0]                op_in,
  input logic                      op_vld,
  input logic [NUM_COLS*OUT_W-1:0] col_act,
  input logic [NUM_COLS-1:0]       col_act_vld,
  input logic [NUM_COLS*3-1:0]     col_op,
  input logic [NUM_COLS-1:0]       col_op_vld
);
  localparam int MW = (IN_W < OUT_W) ? IN_W : OUT_W;

  // R1: outputs held at zero during reset
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (col_act_vld == '0 && col_op_vld == '0);
    end
  end

  // R4 / R8: column 0 takes the adapted slice on a valid row
  assert_col0_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |=> col_act[MW-1:0] == $past(act_in0[MW-1:0]));

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_chk
    if (c == 0) begin : g_first
      assert_act_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> col_act_vld[0] == $past(act_vld));
      assert_op_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> col_op_vld[0] == $past(op_vld));
      assert_op_val_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> col_op[2:0] == $past(op_in));
    end else begin : g_rest
      assert_act_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> col_act_vld[c] == $past(col_act_vld[c-1]));
      assert_op_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> col_op_vld[c] == $past(col_op_vld[c-1]));
      assert_op_val_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_op_vld[c-1] |=> col_op[c*3 +: 3] == $past(col_op[(c-1)*3 +: 3]));
    end

    assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !col_act_vld[c] |-> $stable(col_act[c*OUT_W +: OUT_W]));
    assert_op_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !col_op_vld[c] |-> $stable(col_op[c*3 +: 3]));

    if (OUT_W > IN_W) begin : g_ext
      assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        col_act[c*OUT_W+IN_W +: OUT_W-IN_W] == '0);
    end
  end
endmodule

bind skew_dispatch skew_dispatch_chk #(
  .NUM_COLS (NUM_COLS),
  .IN_W     (IN_W),
  .OUT_W    (OUT_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .act_in0     (act_in[IN_W-1:0]),
  .act_vld     (act_vld),
  .op_in       (op_in),
  .op_vld      (op_vld),
  .col_act     (col_act),
  .col_act_vld (col_act_vld),
  .col_op      (col_op),
  .col_op_vld  (col_op_vld)
);

// File: tb/test_skew_dispatch.sv
`timescale 1ns/1ps
module test_skew_dispatch;
  localparam int NC = 32, IW = 8, OW = 12;
  localparam int NNC = 4, NOW = 5;
  localparam int NCYC = 1400;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC*IW-1:0] act_in;
  logic act_vld, op_vld;
  logic [2:0] op_in;
  logic [NC*OW-1:0] col_act;
  logic [NC-1:0] col_act_vld, col_op_vld;
  logic [NC*3-1:0] col_op;
  logic [NNC*NOW-1:0] n_act;
  logic [NNC-1:0] n_act_vld, n_op_vld;
  logic [NNC*3-1:0] n_op;

  int vectors = 0, misses = 0;
  bit done = 0;

  logic [NC*IW-1:0] h_act [NCYC];
  bit h_av [NCYC];
  bit h_ov [NCYC];
  logic [2:0] h_op [NCYC];

  always #2.5 clk = ~clk;

  skew_dispatch #(.NUM_COLS(NC), .IN_W(IW), .OUT_W(OW)) i_skew_dispatch (
    .clk(clk), .rst_n(rst_n), .act_in(act_in), .act_vld(act_vld),
    .op_in(op_in), .op_vld(op_vld), .col_act(col_act),
    .col_act_vld(col_act_vld), .col_op(col_op), .col_op_vld(col_op_vld));

  skew_dispatch #(.NUM_COLS(NNC), .IN_W(IW), .OUT_W(NOW)) i_skew_dispatch_narrow (
    .clk(clk), .rst_n(rst_n), .act_in(act_in[NNC*IW-1:0]), .act_vld(act_vld),
    .op_in(op_in), .op_vld(op_vld), .col_act(n_act),
    .col_act_vld(n_act_vld), .col_op(n_op), .col_op_vld(n_op_vld));

  function automatic bit exp_av(int n, int k);
    return (n - k >= 0) ? h_av[n-k] : 1'b0;
  endfunction

  function automatic bit exp_ov(int n, int k);
    return (n - k >= 0) ? h_ov[n-k] : 1'b0;
  endfunction

  // Last valid slice that reached column k (R4, R5)
  function automatic logic [IW-1:0] exp_data(int n, int k);
    for (int i = n - k; i >= 0; i--)
      if (h_av[i]) return h_act[i][k*IW +: IW];
    return '0;
  endfunction

  // Last valid opcode that reached column k (R6, R7)
  function automatic logic [2:0] exp_op(int n, int k);
    for (int i = n - k; i >= 0; i--)
      if (h_ov[i]) return h_op[i];
    return '0;
  endfunction

  task automatic cmp(string tag, int col, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s col %0d: got %0h expected %0h", tag, col, act, exp);
    end
  endtask

  task automatic check_cycle(int n);
    for (int k = 0; k < NC; k++) begin
      bit av = exp_av(n, k);
      cmp("R2 data valid", k, 32'(col_act_vld[k]), 32'(av));
      cmp(av ? "R4 data" : "R5 held data", k, 32'(col_act[k*OW +: OW]),
          32'({{(OW-IW){1'b0}}, exp_data(n, k)}));
      cmp("R3 op valid", k, 32'(col_op_vld[k]), 32'(exp_ov(n, k)));
      cmp(exp_ov(n, k) ? "R6 op" : "R7 held op", k, 32'(col_op[k*3 +: 3]),
          32'(exp_op(n, k)));
    end
    for (int k = 0; k < NNC; k++) begin
      logic [IW-1:0] full = exp_data(n, k);
      cmp("R8 narrow data", k, 32'(n_act[k*NOW +: NOW]), 32'(full[NOW-1:0]));
      cmp("R8 narrow valid", k, 32'(n_act_vld[k]), 32'(exp_av(n, k)));
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; act_in = '0; act_vld = 0; op_in = '0; op_vld = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    cmp("R1 reset data valid", 0, 32'(col_act_vld), 32'd0);
    cmp("R1 reset op valid", 0, 32'(col_op_vld), 32'd0);
    cmp("R1 reset data", 0, 32'(|col_act), 32'd0);
    cmp("R1 reset op", 0, 32'(|col_op), 32'd0);
    cmp("R1 reset narrow", 0, 32'(|n_act | |n_act_vld), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < NCYC; n++) begin
      for (int w = 0; w < NC; w++) act_in[w*IW +: IW] = 8'($urandom);
      op_in = 3'($urandom);
      if (n < 40) begin
        act_vld = 1; op_vld = 1;
      end else if (n < 110) begin
        act_vld = (n == 45); op_vld = (n == 52);
      end else if (n < 170) begin
        act_vld = n[0]; op_vld = ~n[0];
      end else if (n < 700) begin
        act_vld = ($urandom % 4) != 0; op_vld = ($urandom % 3) == 0;
      end else begin
        act_vld = ($urandom % 8) == 0; op_vld = ($urandom % 2) == 0;
      end
      h_act[n] = act_in; h_av[n] = act_vld; h_op[n] = op_in; h_ov[n] = op_vld;
      @(posedge clk);
      #1;
      check_cycle(n);
      @(negedge clk);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule